// File: doc/BRIEF.md
# Lockable Key Slot Register Bank

The block is a word-addressed register bank that holds secret keys for a security subsystem. Software places keys into numbered slots, each made of several 32-bit words, and it gives every slot a configuration word and a destination address that a separate export engine reads later. Two one-way lock bits per slot protect the bank. The first hides and freezes the key words. The second freezes the destination address and the export fields.

A key word can be written only once. A second write to the same word is rejected and flagged, so a stale or hostile rewrite cannot replace a key without anyone noticing. Software destroys a key by invalidating its slot. A wipe engine then overwrites the slot's words with zeros through the storage write port, one word per cycle. A small interrupt block collects the rejected-rewrite event, the failed-invalidation event and the wipe-complete event into sticky status bits, with an enable mask and a write-one-to-clear register.

The bus has no handshake. A write takes effect at the clock edge where the write enable is high. Read data shows the addressed register one cycle after the address is presented.

Top module: `kbank_top`

## Requirements
- R1: After reset, all status bits, the enable bits, the irq output, all lock bits and all key word reads are zero. The build register at byte address 0x000 reads NUM_SLOTS in bits [7:0] and WORDS in bits [15:8]. With the defaults it reads 0x0000_0820.
- R2: Each read returns, one cycle after the address, the register at that address. The layout is as follows. Slot s's configuration word is at 0x030+4s. Its destination address is at 0x030+4·NUM_SLOTS+4s (0x0B0 with the defaults). Its key word w is at 0x030+8·NUM_SLOTS+4·(s·WORDS+w) (base 0x130 with the defaults).
- R3: A write to a key word that has not been written since reset or since the last wipe, in an unlocked slot, stores the data. Reading that word back returns the stored data. A key word that has never been written reads zero.
- R4: A write to a key word that already holds data, in an unlocked slot, is discarded. The stored value is kept, and status bit 0 (rewrite) is set.
- R5: Configuration bit 0 is the key lock. Writing 1 sets it, and writing 0 never clears it. While it is set, key writes to the slot are dropped without setting any status bit, and key reads from the slot return zero.
- R6: Configuration bit 1 is the configuration lock, and it is sticky in the same way. Once it is set, writes to the slot's destination address and to configuration bits [22:8] (the export fields) are ignored. A write that sets the lock still updates the export fields in that same write.
- R7: A configuration word reads back as follows: bit 0 key lock, bit 1 configuration lock, bit 2 always 0, bit 3 set when any key word of the slot holds data, bit 4 set while that slot is being wiped, bits [22:8] the export fields, and all other bits 0.
- R8: Writing 1 to configuration bit 2 while no wipe is running invalidates the slot. Its written state clears at once, zeros are written over its WORDS key words on the next WORDS cycles, and status bit 2 (wiped) is set on the last of those cycles. The lock bits do not change. While a wipe runs, key writes to any slot are dropped.
- R9: An invalidation request made while a wipe is running is ignored and sets status bit 1 (invalidation failed).
- R10: The status register at 0x004 is sticky and ignores writes. Writing to 0x00C clears each status bit whose data bit is 1. A status event in the same cycle takes precedence over the clear. Address 0x00C reads zero.
- R11: The enable register at 0x008 holds bits [2:0] and reads them back. The irq output is the OR of the status bits ANDed with the enable bits, and it updates on the same edge as the status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| irq | output | 1 | Interrupt request: any enabled status bit set |

## Verification
The assertions watch, on every cycle, the properties that hold for all traffic. Lock bits never fall. A configuration-locked slot's export fields and destination never change. A locked slot's written state is untouched by key writes, and a rejected rewrite leaves the written state as it was. A slot under wipe never shows a written word. Status bits stay set unless they are cleared, and irq always matches status ANDed with enable. Only the bench scenarios can show the data path end to end: that stored words come back on the right addresses, that locked and wiped words read zero, that the build word and address layout are correct, and that the timing between invalidation, the failed second request, the dropped write during a wipe and the wipe-complete flag comes out as specified.

// File: rtl/kbank_pkg.sv
package kbank_pkg;
  // fixed register offsets (bytes)
  localparam logic [31:0] OFS_BUILD  = 32'h000;
  localparam logic [31:0] OFS_STATUS = 32'h004;
  localparam logic [31:0] OFS_ENABLE = 32'h008;
  localparam logic [31:0] OFS_CLEAR  = 32'h00C;
  localparam logic [31:0] OFS_CFG    = 32'h030;

  // configuration word bit positions
  localparam int CFG_KLOCK   = 0;
  localparam int CFG_CLOCK   = 1;
  localparam int CFG_INVAL   = 2;
  localparam int CFG_WRITTEN = 3;
  localparam int CFG_WIPING  = 4;
  localparam int CFG_EXP_LO  = 8;
  localparam int EXP_W       = 15;

  // status bit positions
  localparam int ST_REWRITE = 0;
  localparam int ST_INVFAIL = 1;
  localparam int ST_WIPED   = 2;
  localparam int ST_W       = 3;

  typedef enum logic [2:0] {
    RG_NONE, RG_BUILD, RG_STATUS, RG_ENABLE, RG_CLEAR, RG_CFG, RG_DEST, RG_KEY
  } region_e;
endpackage

// File: rtl/kbank_keystore.sv
module kbank_keystore #(
  parameter int NUM_SLOTS = 32,
  parameter int WORDS     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int WORD_W   = $clog2(WORDS),
  localparam int DEPTH    = NUM_SLOTS * WORDS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 kw_req,
  input  logic [SLOT_W-1:0]    kw_slot,
  input  logic [WORD_W-1:0]    kw_word,
  input  logic [31:0]          kw_data,
  input  logic [SLOT_W-1:0]    rd_slot,
  input  logic [WORD_W-1:0]    rd_word,
  output logic [31:0]          rd_data,
  input  logic [NUM_SLOTS-1:0] lock_vec,
  input  logic                 inv_req,
  input  logic [SLOT_W-1:0]    inv_slot,
  output logic [NUM_SLOTS-1:0] written_any,
  output logic [NUM_SLOTS-1:0] wiping_vec,
  output logic                 rewrite_pulse,
  output logic                 invfail_pulse,
  output logic                 wiped_pulse
);
  logic [31:0]        mem [DEPTH];
  logic [WORDS-1:0]   wmask [NUM_SLOTS];
  logic               busy;
  logic [SLOT_W-1:0]  wslot;
  logic [WORD_W-1:0]  cnt;
  logic [31:0]        ram_q;
  logic               ok_q;

  logic               ram_we;
  logic [SLOT_W+WORD_W-1:0] ram_waddr;
  logic [31:0]        ram_wdata;
  logic [WORDS-1:0]   cur_mask;
  logic               wr_ok;
  logic               inv_go;

  always_comb begin
    cur_mask      = wmask[kw_slot];
    wr_ok         = kw_req && !busy && !lock_vec[kw_slot] && !cur_mask[kw_word];
    rewrite_pulse = kw_req && !busy && !lock_vec[kw_slot] &&  cur_mask[kw_word];
    inv_go        = inv_req && !busy;
    invfail_pulse = inv_req && busy;
    wiped_pulse   = busy && (cnt == WORD_W'(WORDS - 1));
    ram_we        = busy || wr_ok;
    ram_waddr     = busy ? {wslot, cnt} : {kw_slot, kw_word};
    ram_wdata     = busy ? 32'd0 : kw_data;
  end

  // storage: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_waddr] <= ram_wdata;
    ram_q <= mem[{rd_slot, rd_word}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) wmask[i] <= '0;
      busy  <= 1'b0;
      wslot <= '0;
      cnt   <= '0;
      ok_q  <= 1'b0;
    end else begin
      ok_q <= !lock_vec[rd_slot] && wmask[rd_slot][rd_word];
      if (wr_ok) wmask[kw_slot][kw_word] <= 1'b1;
      if (busy) begin
        cnt <= cnt + 1'b1;
        if (wiped_pulse) busy <= 1'b0;
      end
      if (inv_go) begin
        wmask[inv_slot] <= '0;
        busy  <= 1'b1;
        wslot <= inv_slot;
        cnt   <= '0;
      end
    end
  end

  assign rd_data = ok_q ? ram_q : 32'd0;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign written_any[g] = |wmask[g];
    assign wiping_vec[g]  = busy && (wslot == SLOT_W'(g));
  end

  // R5: a key write to a locked slot leaves its written state untouched
  p_locked_untouched_r5: assert property (@(posedge clk) disable iff (rst)
    (kw_req && lock_vec[kw_slot] && !inv_req) |=> (wmask[$past(kw_slot)] == $past(cur_mask)));
  // R4: a rejected rewrite leaves the written state as it was
  p_rewrite_rejected_r4: assert property (@(posedge clk) disable iff (rst)
    (rewrite_pulse && !inv_req) |=> (wmask[$past(kw_slot)] == $past(cur_mask)));
  // R8: a slot under wipe shows no written word
  p_wipe_clean_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (wmask[wslot] == '0));
  // R9: failed invalidation only while a wipe runs, and it does not restart it
  p_fail_keeps_wipe_r9: assert property (@(posedge clk) disable iff (rst)
    (invfail_pulse && !wiped_pulse) |=> (busy && $stable(wslot)));
endmodule

// File: rtl/kbank_slotcfg.sv
module kbank_slotcfg
  import kbank_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic                 dst_we,
  input  logic [SLOT_W-1:0]    dst_slot,
  input  logic [31:0]          wdata,
  output logic [NUM_SLOTS-1:0] klock_vec,
  output logic [NUM_SLOTS-1:0] clock_vec,
  output logic [EXP_W-1:0]     exp_rd,
  output logic [31:0]          dst_rd
);
  logic [EXP_W-1:0] exp_q [NUM_SLOTS];
  logic [31:0]      dst_q [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      klock_vec <= '0;
      clock_vec <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        exp_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      if (cfg_we) begin
        if (wdata[CFG_KLOCK]) klock_vec[cfg_slot] <= 1'b1;
        if (wdata[CFG_CLOCK]) clock_vec[cfg_slot] <= 1'b1;
        if (!clock_vec[cfg_slot]) exp_q[cfg_slot] <= wdata[CFG_EXP_LO +: EXP_W];
      end
      if (dst_we && !clock_vec[dst_slot]) dst_q[dst_slot] <= wdata;
    end
  end

  assign exp_rd = exp_q[cfg_slot];
  assign dst_rd = dst_q[dst_slot];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
    // R5: key lock never falls
    p_klock_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      klock_vec[g] |=> klock_vec[g]);
    // R6: configuration lock never falls and freezes export settings
    p_clock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      clock_vec[g] |=> clock_vec[g]);
    p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
      clock_vec[g] |=> ($stable(exp_q[g]) && $stable(dst_q[g])));
  end
endmodule

// File: rtl/kbank_irq.sv
module kbank_irq #(
  parameter int ST_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] set_i,
  input  logic            en_we,
  input  logic            clr_we,
  input  logic [ST_W-1:0] wbits,
  output logic [ST_W-1:0] sts_q,
  output logic [ST_W-1:0] en_q,
  output logic            irq_q
);
  logic [ST_W-1:0] clr_m, sts_n, en_n;

  always_comb begin
    clr_m = clr_we ? wbits : '0;
    sts_n = (sts_q & ~clr_m) | set_i;
    en_n  = en_we ? wbits : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_n;
      en_q  <= en_n;
      irq_q <= |(sts_n & en_n);
    end
  end

  // R10: status bits stay set unless cleared
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_m)) == $past(sts_q & ~clr_m)));
  // R11: irq reflects enabled status
  p_irq_match_r11: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(sts_q & en_q));
endmodule

// File: rtl/kbank_top.sv
module kbank_top
  import kbank_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int WORDS     = 8,
  parameter int ADDR_W    = 12,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int WORD_W   = $clog2(WORDS),
  localparam int KIDX_W   = SLOT_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [31:0] DST_BASE   = OFS_CFG + 32'(4 * NUM_SLOTS);
  localparam logic [31:0] KEY_BASE   = DST_BASE + 32'(4 * NUM_SLOTS);
  localparam logic [31:0] KEY_END    = KEY_BASE + 32'(4 * NUM_SLOTS * WORDS);
  localparam logic [31:0] BUILD_WORD = 32'((WORDS << 8) | NUM_SLOTS);

  region_e            region, region_q;
  logic [31:0]        a32;
  logic [SLOT_W-1:0]  cfg_slot, dst_slot;
  logic [KIDX_W-1:0]  key_idx;
  logic [SLOT_W-1:0]  key_slot;
  logic [WORD_W-1:0]  key_word;

  always_comb begin
    a32      = 32'(bus_addr);
    cfg_slot = bus_addr[SLOT_W+1:2] - OFS_CFG[SLOT_W+1:2];
    dst_slot = bus_addr[SLOT_W+1:2] - DST_BASE[SLOT_W+1:2];
    key_idx  = bus_addr[KIDX_W+1:2] - KEY_BASE[KIDX_W+1:2];
    key_slot = key_idx[KIDX_W-1:WORD_W];
    key_word = key_idx[WORD_W-1:0];
    region   = RG_NONE;
    if (a32[1:0] == 2'b00) begin
      if      (a32 == OFS_BUILD)                   region = RG_BUILD;
      else if (a32 == OFS_STATUS)                  region = RG_STATUS;
      else if (a32 == OFS_ENABLE)                  region = RG_ENABLE;
      else if (a32 == OFS_CLEAR)                   region = RG_CLEAR;
      else if (a32 >= OFS_CFG  && a32 < DST_BASE)  region = RG_CFG;
      else if (a32 >= DST_BASE && a32 < KEY_BASE)  region = RG_DEST;
      else if (a32 >= KEY_BASE && a32 < KEY_END)   region = RG_KEY;
    end
  end

  logic [NUM_SLOTS-1:0] klock_vec, clock_vec, written_any, wiping_vec;
  logic [EXP_W-1:0]     exp_rd;
  logic [31:0]          dst_rd, key_rd;
  logic                 rewrite_p, invfail_p, wiped_p;
  logic [ST_W-1:0]      sts, en;
  logic                 cfg_we;

  assign cfg_we = bus_we && (region == RG_CFG);

  kbank_slotcfg #(.NUM_SLOTS(NUM_SLOTS)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .dst_we(bus_we && (region == RG_DEST)), .dst_slot(dst_slot),
    .wdata(bus_wdata),
    .klock_vec(klock_vec), .clock_vec(clock_vec),
    .exp_rd(exp_rd), .dst_rd(dst_rd)
  );

  kbank_keystore #(.NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS)) u_keys (
    .clk(clk), .rst(rst),
    .kw_req(bus_we && (region == RG_KEY)), .kw_slot(key_slot), .kw_word(key_word),
    .kw_data(bus_wdata),
    .rd_slot(key_slot), .rd_word(key_word), .rd_data(key_rd),
    .lock_vec(klock_vec),
    .inv_req(cfg_we && bus_wdata[CFG_INVAL]), .inv_slot(cfg_slot),
    .written_any(written_any), .wiping_vec(wiping_vec),
    .rewrite_pulse(rewrite_p), .invfail_pulse(invfail_p), .wiped_pulse(wiped_p)
  );

  logic [ST_W-1:0] st_set;
  always_comb begin
    st_set             = '0;
    st_set[ST_REWRITE] = rewrite_p;
    st_set[ST_INVFAIL] = invfail_p;
    st_set[ST_WIPED]   = wiped_p;
  end

  kbank_irq #(.ST_W(ST_W)) u_irq (
    .clk(clk), .rst(rst), .set_i(st_set),
    .en_we(bus_we && (region == RG_ENABLE)),
    .clr_we(bus_we && (region == RG_CLEAR)),
    .wbits(bus_wdata[ST_W-1:0]),
    .sts_q(sts), .en_q(en), .irq_q(irq)
  );

  logic [31:0] cfg_word, reg_n, reg_q;
  always_comb begin
    cfg_word                        = '0;
    cfg_word[CFG_KLOCK]             = klock_vec[cfg_slot];
    cfg_word[CFG_CLOCK]             = clock_vec[cfg_slot];
    cfg_word[CFG_WRITTEN]           = written_any[cfg_slot];
    cfg_word[CFG_WIPING]            = wiping_vec[cfg_slot];
    cfg_word[CFG_EXP_LO +: EXP_W]   = exp_rd;
    case (region)
      RG_BUILD:  reg_n = BUILD_WORD;
      RG_STATUS: reg_n = 32'(sts);
      RG_ENABLE: reg_n = 32'(en);
      RG_CFG:    reg_n = cfg_word;
      RG_DEST:   reg_n = dst_rd;
      default:   reg_n = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      region_q <= RG_NONE;
      reg_q    <= '0;
    end else begin
      region_q <= region;
      reg_q    <= reg_n;
    end
  end

  assign bus_rdata = (region_q == RG_KEY) ? key_rd : reg_q;
endmodule

// File: tb/sim_kbank_top.sv
module sim_kbank_top;
  localparam int NS = 32;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  kbank_top #(.NUM_SLOTS(NS), .WORDS(NW), .ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  // reference model
  logic [31:0] mkey [NS][NW];
  bit          mwr  [NS][NW];
  bit          mkl  [NS];
  bit          mcl  [NS];
  logic [14:0] mexp [NS];
  logic [31:0] mdst [NS];
  logic [2:0]  msts, men;

  function automatic logic [11:0] a_cfg(int s); return 12'(32'h30 + 4*s); endfunction
  function automatic logic [11:0] a_dst(int s); return 12'(32'hB0 + 4*s); endfunction
  function automatic logic [11:0] a_key(int s, int w); return 12'(32'h130 + 32*s + 4*w); endfunction

  function automatic logic [31:0] key_exp(int s, int w);
    return (mkl[s] || !mwr[s][w]) ? 32'd0 : mkey[s][w];
  endfunction

  function automatic logic [31:0] cfg_exp(int s, bit wiping);
    bit any = 1'b0;
    for (int w = 0; w < NW; w++) any |= mwr[s][w];
    return {9'b0, mexp[s], 3'b0, wiping, any, 1'b0, mcl[s], mkl[s]};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic chk_irq(string tag);
    chk(tag, 32'(irq), 32'(|(msts & men)));
  endtask

  // model-side writes (no invalidation here)
  task automatic m_key(int s, int w, logic [31:0] d);
    wr(a_key(s, w), d);
    if (!mkl[s]) begin
      if (mwr[s][w]) msts[0] = 1'b1;
      else begin mwr[s][w] = 1'b1; mkey[s][w] = d; end
    end
  endtask

  task automatic m_cfg(int s, logic [31:0] d);
    wr(a_cfg(s), d);
    if (!mcl[s]) mexp[s] = d[22:8];
    mkl[s] |= d[0];
    mcl[s] |= d[1];
  endtask

  task automatic m_dst(int s, logic [31:0] d);
    wr(a_dst(s), d);
    if (!mcl[s]) mdst[s] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] seedv;
    seedv = $urandom(32'd1234);
    for (int s = 0; s < NS; s++) begin
      mkl[s] = 0; mcl[s] = 0; mexp[s] = '0; mdst[s] = '0;
      for (int w = 0; w < NW; w++) begin mwr[s][w] = 0; mkey[s][w] = '0; end
    end
    msts = '0; men = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and build word
    rd(12'h000, v); chk("R1 build", v, 32'h0000_0820);
    rd(12'h004, v); chk("R1 status", v, 32'd0);
    rd(12'h008, v); chk("R1 enable", v, 32'd0);
    rd(a_key(0, 0), v); chk("R1 key", v, 32'd0);
    rd(a_cfg(31), v); chk("R1 cfg", v, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R3 / R2: store and read back a full slot
    for (int w = 0; w < NW; w++) m_key(2, w, 32'hC0DE_0000 + 32'(w) * 32'h1111);
    for (int w = 0; w < NW; w++) begin rd(a_key(2, w), v); chk("R3 readback", v, key_exp(2, w)); end
    rd(a_key(3, 0), v); chk("R3 unwritten", v, 32'd0);
    rd(a_cfg(2), v); chk("R7 written bit", v, 32'h8);

    // R4: rewrite rejected and flagged
    m_key(2, 3, 32'hDEAD_BEEF);
    rd(a_key(2, 3), v); chk("R4 kept", v, 32'hC0DE_3333);
    rd(12'h004, v); chk("R4 flag", v, 32'h1);
    chk_irq("R11 masked");
    wr(12'h008, 32'h7); men = 3'h7;
    chk_irq("R11 enabled");
    rd(12'h008, v); chk("R11 enable readback", v, 32'h7);
    wr(12'h004, 32'h0);
    rd(12'h004, v); chk("R10 status ignores write", v, 32'h1);
    rd(12'h00C, v); chk("R10 clear reads zero", v, 32'd0);
    wr(12'h00C, 32'h1); msts = '0;
    chk_irq("R10 cleared irq");
    rd(12'h004, v); chk("R10 cleared", v, 32'd0);

    // R5: key lock
    m_cfg(2, 32'h1);
    rd(a_key(2, 0), v); chk("R5 locked read", v, 32'd0);
    m_key(2, 0, 32'h1234_5678);
    rd(12'h004, v); chk("R5 silent drop", v, 32'd0);
    m_cfg(2, 32'h0);
    rd(a_cfg(2), v); chk("R5 sticky", v, cfg_exp(2, 0));

    // R6: configuration lock set in the same write as export fields
    m_dst(4, 32'hAAAA_5555);
    m_cfg(4, 32'h0055_AA02);
    m_cfg(4, 32'h0011_2200);
    m_dst(4, 32'h0BAD_F00D);
    rd(a_cfg(4), v); chk("R6 export frozen", v, cfg_exp(4, 0));
    chk("R7 layout", v, 32'h0055_AA02);
    rd(a_dst(4), v); chk("R6 dest frozen", v, 32'hAAAA_5555);

    // R8 / R9: invalidate, second request fails, writes dropped during wipe
    for (int w = 0; w < NW; w++) m_key(6, w, 32'h6600_0000 + 32'(w));
    wr(a_cfg(6), 32'h4);
    for (int w = 0; w < NW; w++) mwr[6][w] = 0;
    wr(a_cfg(7), 32'h4); msts[1] = 1'b1;
    wr(a_key(9, 0), 32'h9999_9999);
    rd(a_cfg(6), v); chk("R8 wiping bit", v, 32'h10);
    repeat (10) @(negedge clk);
    msts[2] = 1'b1;
    rd(12'h004, v); chk("R9 fail and R8 wiped", v, 32'(msts));
    chk_irq("R11 after wipe");
    for (int w = 0; w < NW; w++) begin rd(a_key(6, w), v); chk("R8 wiped word", v, 32'd0); end
    rd(a_cfg(6), v); chk("R8 cfg after wipe", v, 32'd0);
    rd(a_key(9, 0), v); chk("R8 dropped during wipe", v, 32'd0);
    m_key(6, 0, 32'hFEED_0001);
    rd(a_key(6, 0), v); chk("R8 rewrite after wipe", v, 32'hFEED_0001);
    rd(12'h004, v); chk("R8 no rewrite flag", v, 32'(msts));
    wr(12'h00C, 32'h7); msts = '0;

    // random phase
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 9);
      int s  = int'($urandom % NS);
      int w  = int'($urandom % NW);
      logic [31:0] d = $urandom;
      case (op)
        0, 1: m_key(s, w, d);
        2, 3: begin rd(a_key(s, w), v); chk("R3 random key", v, key_exp(s, w)); end
        4: begin
          d[2] = 1'b0;
          if ($urandom % 8 != 0) d[1:0] = 2'b00;
          m_cfg(s, d);
        end
        5: begin rd(a_cfg(s), v); chk("R7 random cfg", v, cfg_exp(s, 0)); end
        6: begin
          if ($urandom % 2 == 0) m_dst(s, d);
          else begin rd(a_dst(s), v); chk("R2 random dest", v, mdst[s]); end
        end
        7: begin
          if ($urandom % 2 == 0) begin wr(12'h008, d); men = d[2:0]; end
          else begin wr(12'h00C, d); msts &= ~d[2:0]; end
        end
        default: begin rd(12'h004, v); chk("R10 random status", v, 32'(msts)); end
      endcase
      chk_irq("R11 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule